// File: doc/BRIEF.md
# Reloadable Tick Timer with Timestamp

This block is the tick source for an operating system. It holds two counters that run from the timer clock. The first is a 32-bit timestamp that counts up by one every clock and wraps freely. The second is an event timer that counts down and raises an interrupt each time it runs out. Software uses the timestamp as a clocksource and can load it with any value. It uses the event timer for a periodic scheduler tick, or arms it once for the next deadline.

The event timer is set up through a single reload word. Its two lowest bits are control fields: bit 0 enables the timer and bit 1 selects single-shot operation. The upper bits hold the reload value, and its two low bits are always treated as zero, so a reload value is always a multiple of four. Expiry sets a sticky pending flag, which drives the interrupt line. Software clears the flag by writing a one to its bit in the status word.

The register bus is a simple one. A write takes effect at the clock edge where `wr_en` is sampled high. A read returns its data on `rdata` one clock after `rd_en` is sampled. That data is the register value as it stood just before that edge. The nominal clock is about 66.7 MHz.

Top module: `tick_timer`

## Requirements
- R1: After reset, the timestamp, the down-count and the reload word are all zero, the timer is disabled, and `irq` is low.
- R2: When not being written, the timestamp increases by one on every clock and wraps from 0xFFFFFFFF to 0.
- R3: A write to address 0 loads the timestamp with `wdata`, and counting continues upward from that value. A write of 0 therefore resets it.
- R4: Address 1 is the reload word, with bit 0 = enable, bit 1 = single-shot and bits 31:2 = reload value. The loaded count always has bits 1:0 equal to zero. Reading address 1 returns {reload value, single-shot, enable}.
- R5: A write to address 1 with enable set loads the down-count with the reload value. The count then drops by one per clock, and expiry occurs on the clock where the count is zero. For a reload value R written at edge E, pending first becomes set at edge E+R+1.
- R6: With enable set and single-shot clear, the timer reloads itself on expiry, so pending is set again every R+1 clocks.
- R7: With single-shot set, the first expiry clears the enable bit. The count stays at zero and no further expiry occurs.
- R8: A write to address 1 with enable clear, such as writing 0, stops the timer and zeroes the count. No expiry follows.
- R9: Address 2 bit 0 is the pending flag. Writing 1 to that bit clears it, and writing 0 has no effect. If an expiry and a clear fall on the same edge, pending stays set.
- R10: `irq` equals the pending flag.
- R11: With enable set and a reload value of zero, the timer expires on the clock right after the write.
- R12: Reads are registered. Address 3 returns the current down-count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 timestamp, 1 reload, 2 status, 3 count |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after `rd_en` |
| irq | output | 1 | Timer interrupt, equal to the pending flag |

## Verification
The bench checks the exact edge of the first expiry. This catches an off-by-one in the expiry point, where pending would rise one clock early or late against R+1. It checks that a zero reload fires on the very next clock. A design that waited a full wrap would fail here. It checks that single-shot really halts: if the count rolled on, or the enable bit were left set, a second interrupt would appear or the readback would be wrong. It also checks that a clear colliding with an expiry loses, since a design that lets the clear win would drop a tick. The timestamp wrap, and writes to the low control bits leaking into the count, are covered as well.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    SEL_STAMP  = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_COUNT  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_BITS = 2;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned OS_BIT    = 1;
  localparam int unsigned PEND_BIT  = 0;
endpackage

// File: rtl/tick_stamp_counter.sv
module tick_stamp_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] stamp_q
);
  always_ff @(posedge clk) begin
    if (rst)        stamp_q <= '0;
    else if (ld_we) stamp_q <= ld_data;
    else            stamp_q <= stamp_q + 1'b1;
  end
endmodule

// File: rtl/tick_event_timer.sv
module tick_event_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [DW-1:0] ld_data,
  input  logic          clr_pend,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] rl_q,
  output logic          en_q,
  output logic          os_q,
  output logic          pend_q,
  output logic          exp_o
);
  localparam int unsigned VW = DW - CTRL_BITS;

  logic [DW-1:0] ld_val;
  assign ld_val = {ld_data[DW-1:CTRL_BITS], {CTRL_BITS{1'b0}}};
  assign exp_o  = en_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rl_q  <= '0;
      en_q  <= 1'b0;
      os_q  <= 1'b0;
    end else if (ld_we) begin
      rl_q  <= ld_val;
      en_q  <= ld_data[EN_BIT];
      os_q  <= ld_data[OS_BIT];
      cnt_q <= ld_data[EN_BIT] ? ld_val : '0;
    end else if (exp_o) begin
      if (os_q) en_q  <= 1'b0;
      else      cnt_q <= rl_q;
    end else if (en_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           pend_q <= 1'b0;
    else if (exp_o)    pend_q <= 1'b1;
    else if (clr_pend) pend_q <= 1'b0;
  end

  logic [VW-1:0] unused_low;
  assign unused_low = rl_q[DW-1:CTRL_BITS];
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic          stamp_we, rl_we, clr_pend;
  logic [DW-1:0] stamp_q, cnt_q, rl_q;
  logic          en_q, os_q, pend_q, exp_w;
  logic [DW-1:0] rd_mux;

  assign stamp_we = wr_en && (addr == AW'(SEL_STAMP));
  assign rl_we    = wr_en && (addr == AW'(SEL_RELOAD));
  assign clr_pend = wr_en && (addr == AW'(SEL_STATUS)) && wdata[PEND_BIT];

  tick_stamp_counter #(.DW(DW)) u_stamp (
    .clk(clk), .rst(rst), .ld_we(stamp_we), .ld_data(wdata), .stamp_q(stamp_q)
  );

  tick_event_timer #(.DW(DW)) u_evt (
    .clk(clk), .rst(rst), .ld_we(rl_we), .ld_data(wdata), .clr_pend(clr_pend),
    .cnt_q(cnt_q), .rl_q(rl_q), .en_q(en_q), .os_q(os_q),
    .pend_q(pend_q), .exp_o(exp_w)
  );

  always_comb begin
    unique case (addr)
      AW'(SEL_STAMP):  rd_mux = stamp_q;
      AW'(SEL_RELOAD): rd_mux = {rl_q[DW-1:CTRL_BITS], os_q, en_q};
      AW'(SEL_STATUS): rd_mux = {{(DW-1){1'b0}}, pend_q};
      default:         rd_mux = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign irq = pend_q;
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] stamp_q,
  input logic [DW-1:0] cnt_q,
  input logic          en_q,
  input logic          os_q,
  input logic          pend_q,
  input logic          exp_w,
  input logic          irq
);
  logic w_stamp, w_rl, w_clr;
  assign w_stamp = wr_en && addr == 2'd0;
  assign w_rl    = wr_en && addr == 2'd1;
  assign w_clr   = wr_en && addr == 2'd2 && wdata[0];

  p_stamp_step_r2: assert property (@(posedge clk) disable iff (rst)
    !w_stamp |=> stamp_q == $past(stamp_q) + 1'b1);

  p_stamp_load_r3: assert property (@(posedge clk) disable iff (rst)
    w_stamp |=> stamp_q == $past(wdata));

  p_load_align_r4: assert property (@(posedge clk) disable iff (rst)
    (w_rl && wdata[0]) |=> (cnt_q[1:0] == 2'b00 && cnt_q[DW-1:2] == $past(wdata[DW-1:2])));

  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (en_q && cnt_q != '0 && !w_rl) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_oneshot_halt_r7: assert property (@(posedge clk) disable iff (rst)
    (exp_w && os_q && !w_rl) |=> !en_q);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !w_rl) |=> $stable(cnt_q));

  p_expire_sets_r9: assert property (@(posedge clk) disable iff (rst)
    exp_w |=> pend_q);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (w_clr && !exp_w) |=> !irq);
endmodule

bind tick_timer tick_timer_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .stamp_q(stamp_q), .cnt_q(cnt_q), .en_q(en_q), .os_q(os_q),
  .pend_q(pend_q), .exp_w(exp_w), .irq(irq)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] seed_v;

  always #2.5 clk = ~clk;

  tick_timer u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [31:0] aligned(input logic [31:0] v);
    return {v[31:2], 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Arm timer with reload r, check first expiry edge (R5/R11).
  task automatic arm_check(input string tag, input logic [31:0] r, input logic os);
    logic [31:0] rv;
    rv = aligned(r);
    wr(2'd1, rv | {30'd0, os, 1'b1});
    wait_n(int'(rv));
    chk({tag, " before expiry"}, {31'd0, irq}, 32'd0);
    wait_n(1);
    chk({tag, " at expiry"}, {31'd0, irq}, 32'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, x, r;
    seed_v = $urandom(32'h5eed);
    wait_n(4);
    // R1: reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    rst = 1'b0;
    rd(2'd1, d); chk("R1 reload word", d, 32'd0);
    rd(2'd3, d); chk("R1 count", d, 32'd0);

    // R2/R3: stamp load, step and wrap
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R3 stamp load", d, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 stamp wrap", d, 32'd0);
    for (int k = 0; k < 6; k++) begin
      x = $urandom;
      wr(2'd0, x);
      rd(2'd0, d); chk("R3 stamp random load", d, x);
      wait_n(3);
      rd(2'd0, d); chk("R2 stamp step", d, x + 32'd4);
    end
    wr(2'd0, 32'd0);
    rd(2'd0, d); chk("R3 stamp zero", d, 32'd0);

    // R11: zero reload expires next clock
    arm_check("R11 zero reload", 32'd0, 1'b0);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd1);
    chk("R9 clear", {31'd0, irq}, 32'd0);

    // R4: low bits ignored as count, readback of control
    wr(2'd1, 32'h0000_0077);
    rd(2'd3, d); chk("R4 aligned count", d, 32'h74);
    rd(2'd1, d); chk("R4 reload readback", d, 32'h77);
    wr(2'd1, 32'd0);

    // R5/R6/R10: random periodic and single-shot
    for (int k = 0; k < 8; k++) begin
      r = 32'd4 + aligned($urandom % 60);
      if (k[0]) begin
        arm_check("R5 periodic first", r, 1'b0);
        wr(2'd2, 32'd1);
        chk("R9 cleared", {31'd0, irq}, 32'd0);
        wait_n(int'(r) - 1);
        chk("R6 before second", {31'd0, irq}, 32'd0);
        wait_n(1);
        chk("R6 second expiry", {31'd0, irq}, 32'd1);
        chk("R10 irq equals pending", {31'd0, irq}, 32'd1);
      end else begin
        arm_check("R5 oneshot first", r, 1'b1);
        rd(2'd1, d); chk("R7 enable cleared", d, r | 32'd2);
        wr(2'd2, 32'd1);
        wait_n(2 * int'(r) + 5);
        chk("R7 no second expiry", {31'd0, irq}, 32'd0);
        rd(2'd3, d); chk("R7 count held zero", d, 32'd0);
      end
      wr(2'd1, 32'd0);
      wr(2'd2, 32'd1);
    end

    // R8: disable mid-count
    wr(2'd1, 32'd41);
    wait_n(5);
    wr(2'd1, 32'd0);
    wait_n(60);
    chk("R8 no expiry after stop", {31'd0, irq}, 32'd0);
    rd(2'd3, d); chk("R8 count zeroed", d, 32'd0);

    // R9: write 0 no effect; collision keeps pending
    arm_check("R5 small", 32'd8, 1'b1);
    wr(2'd2, 32'd0);
    chk("R9 write zero ignored", {31'd0, irq}, 32'd1);
    wr(2'd1, 32'd1);
    wr(2'd2, 32'd1);
    chk("R9 expiry beats clear", {31'd0, irq}, 32'd1);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd1);
    chk("R9 clear after stop", {31'd0, irq}, 32'd0);
    rd(2'd2, d); chk("R12 status read", d, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule